// File: doc/BRIEF.md
# Pattern Channel Bank: Drive and Expected-Value Test

This block serves one bank of bidirectional pattern channels, sixteen by default. For every pattern step a sequencer supplies a 3-bit action per channel. The action tells the channel to drive a fixed level, to float, to forward the line clock, or to release the pin and check it against an expected level. The block turns the registered actions into pad data and pad enables. When the sequencer raises the strobe, which it places on the last rising line-clock edge of the step, the block compares every channel under test against its expected level.

Failures are reported in three ways. A combinational step-fail flag goes to the sequencer for conditional branching and stop-on-fail. One registered strobe pulse is produced for each group of eight channels. A sticky per-channel log accumulates every failing channel until it is cleared. The electrical behaviour of the pads is not modelled: each pad is a plain logic input.

The sequencer raises the step-load pulse in the master-clock cycle that matches the falling line-clock edge ending the previous step. The new actions take effect from the next clock edge. While no pattern runs, every pin is released and no test is evaluated.

Top module: `chan_bank`

## Requirements
- R1: In reset, every pad enable, the sticky log, the group fail strobes and the step-fail flag are all 0.
- R2: Action 3'b000 drives 0 and action 3'b001 drives 1, with the pad enable at 1. Both take effect in the first clock cycle after the clock edge that samples step_load_i.
- R3: Action 3'b010 releases the pin (pad enable 0). The unused codes 3'b110 and 3'b111 behave exactly like 3'b010.
- R4: Action 3'b011 (expect high) and action 3'b100 (expect low) leave the pin undriven for the whole step.
- R5: Action 3'b101 drives the pin with the pad enable at 1, and pad data follows line_clk_i combinationally for as long as the step lasts.
- R6: A channel's action changes only on a clock edge that samples step_load_i high. Changes on step_code_i at other times have no effect on the pads.
- R7: While run_i is 0, every pad enable is 0 and no test is evaluated, so nothing is flagged, strobed or logged.
- R8: step_fail_o is combinational. It is 1 exactly when strobe_i is 1, run_i is 1, and at least one channel fails. A channel fails when it holds action 3'b011 with its pad at 0, or action 3'b100 with its pad at 1.
- R9: fail_grp_o[g] pulses for the one cycle after a clock edge where strobe_i is 1 and some channel in 8*g to 8*g+7 failed. Bit 0 covers channels 0 to 7 and bit 1 covers channels 8 to 15.
- R10: A failing test sets the channel's bit in sticky_o at the strobe edge. Later passing tests never clear a bit, and bits from later fails are added to the existing set.
- R11: clr_i clears sticky_o at the next clock edge, and it wins over a fail on the same edge.
- R12: With strobe_i at 0, mismatching pads on channels under test produce no step-fail, no group strobe and no sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Pattern running |
| step_load_i | input | 1 | Take step_code_i as the new step's actions |
| step_code_i | input | 48 | 3-bit action per channel; channel c uses bits 3c+2:3c |
| line_clk_i | input | 1 | Line clock level, forwarded by action 3'b101 |
| strobe_i | input | 1 | Test point of the current step |
| pad_i | input | 16 | Logic levels seen at the pads |
| clr_i | input | 1 | Synchronous clear of the sticky fail log |
| pad_o | output | 16 | Pad drive data |
| pad_oe_o | output | 16 | Pad drive enable |
| step_fail_o | output | 1 | Any test failing at this strobe (combinational) |
| fail_grp_o | output | 2 | One-cycle fail strobe per group of eight channels |
| sticky_o | output | 16 | Accumulated per-channel fail log |

## Verification
Pad data and enables for fixed-level, release and test actions are due one cycle after the edge that samples step_load_i, so the bench checks them half a period after that edge. The forwarded clock and step_fail_o are combinational and are checked a moment after the stimulus changes, before the next edge. Group strobes and the sticky log are registered at the strobe edge, so they are checked half a period after it. A further check confirms that each group strobe has dropped one cycle later.

// File: rtl/chan_bank_pkg.sv
package chan_bank_pkg;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    ACT_DRV0   = 3'b000,
    ACT_DRV1   = 3'b001,
    ACT_REL    = 3'b010,
    ACT_TST_HI = 3'b011,
    ACT_TST_LO = 3'b100,
    ACT_CLK    = 3'b101
  } act_e;

  function automatic logic act_is_test(logic [CODE_W-1:0] c);
    return (c == ACT_TST_HI) || (c == ACT_TST_LO);
  endfunction
endpackage

// File: rtl/chan_slice.sv
module chan_slice
  import chan_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              run_i,
  input  logic              line_clk_i,
  input  logic              strobe_i,
  input  logic              pad_i,
  output logic              pad_o,
  output logic              oe_o,
  output logic              fail_o
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= ACT_REL;
    else if (load_i) code_q <= code_i;
  end

  always_comb begin
    pad_o = 1'b0;
    oe_o  = 1'b0;
    unique case (code_q)
      ACT_DRV0: begin pad_o = 1'b0;       oe_o = 1'b1; end
      ACT_DRV1: begin pad_o = 1'b1;       oe_o = 1'b1; end
      ACT_CLK:  begin pad_o = line_clk_i; oe_o = 1'b1; end
      default:  begin pad_o = 1'b0;       oe_o = 1'b0; end
    endcase
    if (!run_i) oe_o = 1'b0;
  end

  // expected-level compare, only at the strobe point of a running pattern
  always_comb begin
    fail_o = 1'b0;
    if (strobe_i && run_i) begin
      if (code_q == ACT_TST_HI) fail_o = ~pad_i;
      if (code_q == ACT_TST_LO) fail_o = pad_i;
    end
  end

  AST_TEST_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && act_is_test(code_i) |=> !oe_o); // R4

  AST_CLK_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && run_i && code_i == ACT_CLK ##1 run_i |-> oe_o && pad_o == line_clk_i); // R5

  AST_NO_FAIL_OFF_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |-> !fail_o); // R12
endmodule

// File: rtl/fail_log.sv
module fail_log #(
  parameter int unsigned N_CH    = 16,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned N_GRP  = N_CH / GROUP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  fail_i,
  input  logic             clr_i,
  output logic [N_CH-1:0]  sticky_o,
  output logic [N_GRP-1:0] grp_o
);
  logic [N_CH-1:0]  sticky_q;
  logic [N_GRP-1:0] grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sticky_q <= '0;
    else if (clr_i) sticky_q <= '0;
    else            sticky_q <= sticky_q | fail_i;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) grp_q[g] <= 1'b0;
      else         grp_q[g] <= |fail_i[g*GROUP_W +: GROUP_W];
    end

    AST_GRP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_q[g] |-> $past(|fail_i[g*GROUP_W +: GROUP_W])); // R9
  end

  assign sticky_o = sticky_q;
  assign grp_o    = grp_q;

  AST_STICKY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (sticky_q & $past(sticky_q)) == $past(sticky_q)); // R10

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sticky_q == '0); // R11
endmodule

// File: rtl/chan_bank.sv
module chan_bank
  import chan_bank_pkg::*;
#(
  parameter int unsigned N_CH    = 16,
  parameter int unsigned GROUP_W = 8,
  localparam int unsigned N_GRP  = N_CH / GROUP_W,
  localparam int unsigned CODE_BITS = N_CH * CODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic                 step_load_i,
  input  logic [CODE_BITS-1:0] step_code_i,
  input  logic                 line_clk_i,
  input  logic                 strobe_i,
  input  logic [N_CH-1:0]      pad_i,
  input  logic                 clr_i,
  output logic [N_CH-1:0]      pad_o,
  output logic [N_CH-1:0]      pad_oe_o,
  output logic                 step_fail_o,
  output logic [N_GRP-1:0]     fail_grp_o,
  output logic [N_CH-1:0]      sticky_o
);
  logic [N_CH-1:0] fail_vec;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    chan_slice i_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (step_load_i),
      .code_i     (step_code_i[c*CODE_W +: CODE_W]),
      .run_i      (run_i),
      .line_clk_i (line_clk_i),
      .strobe_i   (strobe_i),
      .pad_i      (pad_i[c]),
      .pad_o      (pad_o[c]),
      .oe_o       (pad_oe_o[c]),
      .fail_o     (fail_vec[c])
    );
  end

  assign step_fail_o = |fail_vec;

  fail_log #(.N_CH(N_CH), .GROUP_W(GROUP_W)) i_log (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fail_i   (fail_vec),
    .clr_i    (clr_i),
    .sticky_o (sticky_o),
    .grp_o    (fail_grp_o)
  );

  AST_IDLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> pad_oe_o == '0); // R7

  AST_FAIL_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_fail_o |-> strobe_i && run_i); // R8

  AST_GRP_IMPLIES_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fail_grp_o) && !$past(clr_i) |-> sticky_o != '0); // R10
endmodule

// File: tb/test_chan_bank.sv
module test_chan_bank;
  localparam int CLK_P = 10;
  localparam int N = 16;

  typedef struct packed {
    logic [2:0]  lo;
    logic [2:0]  hi;
    logic [15:0] pad;
    logic [15:0] oe;
    logic [15:0] dat;
    logic [1:0]  grp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b000, 3'b001, 16'h0000, 16'hFFFF, 16'hFF00, 2'b00}, // R2
    '{3'b001, 3'b000, 16'h0000, 16'hFFFF, 16'h00FF, 2'b00}, // R2
    '{3'b010, 3'b110, 16'hFFFF, 16'h0000, 16'h0000, 2'b00}, // R3
    '{3'b011, 3'b100, 16'h00FF, 16'h0000, 16'h0000, 2'b00}, // R4 pass
    '{3'b011, 3'b100, 16'hFF00, 16'h0000, 16'h0000, 2'b11}, // R8 both fail
    '{3'b100, 3'b011, 16'hFFFF, 16'h0000, 16'h0000, 2'b01}, // R9 low group
    '{3'b101, 3'b111, 16'h0000, 16'h00FF, 16'h00FF, 2'b00}, // R5 R3
    '{3'b000, 3'b011, 16'h0000, 16'h00FF, 16'h0000, 2'b10}  // R9 high group
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, run_i = 1'b0, step_load_i = 1'b0;
  logic [N*3-1:0] step_code_i = '0;
  logic line_clk_i = 1'b0, strobe_i = 1'b0, clr_i = 1'b0;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] pad_o, pad_oe_o, sticky_o;
  logic step_fail_o;
  logic [1:0] fail_grp_o;

  int checks = 0, errors = 0;
  bit done = 0;

  chan_bank i_chan_bank (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*3-1:0] codes(logic [2:0] lo, logic [2:0] hi);
    logic [N*3-1:0] r;
    for (int c = 0; c < N; c++) r[c*3 +: 3] = (c < 8) ? lo : hi;
    return r;
  endfunction

  task automatic load(logic [N*3-1:0] c);
    @(negedge clk_i); step_code_i = c; step_load_i = 1'b1;
    @(negedge clk_i); step_load_i = 1'b0; #1;
  endtask

  task automatic strobe(logic [N-1:0] p);
    @(negedge clk_i); pad_i = p; strobe_i = 1'b1;
    @(negedge clk_i); strobe_i = 1'b0; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*3-1:0] cv;
    #1;
    chk("R1 oe", pad_oe_o, 0);
    chk("R1 sticky", sticky_o, 0);
    chk("R1 grp", fail_grp_o, 0);
    chk("R1 step_fail", step_fail_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1; run_i = 1'b1; line_clk_i = 1'b1;

    for (int i = 0; i < 8; i++) begin
      load(codes(VECS[i].lo, VECS[i].hi));
      chk($sformatf("R2/R3/R4 oe v%0d", i), pad_oe_o, VECS[i].oe);
      chk($sformatf("R2/R5 data v%0d", i), pad_o & VECS[i].oe, VECS[i].dat);
      @(negedge clk_i); pad_i = VECS[i].pad; strobe_i = 1'b1; #1;
      chk($sformatf("R8 step_fail v%0d", i), step_fail_o, |VECS[i].grp);
      @(negedge clk_i); strobe_i = 1'b0; #1;
      chk($sformatf("R9 grp v%0d", i), fail_grp_o, VECS[i].grp);
      @(negedge clk_i); #1;
      chk($sformatf("R9 grp drop v%0d", i), fail_grp_o, 0);
    end

    // R5: forwarded clock follows the line clock
    cv = codes(3'b010, 3'b010); cv[3*3 +: 3] = 3'b101;
    load(cv);
    line_clk_i = 1'b0; #1;
    chk("R5 clk low", {pad_oe_o[3], pad_o[3]}, 2'b10);
    line_clk_i = 1'b1; #1;
    chk("R5 clk high", {pad_oe_o[3], pad_o[3]}, 2'b11);

    // R6: code change without load is ignored
    step_code_i = codes(3'b001, 3'b001);
    @(negedge clk_i); @(negedge clk_i); #1;
    chk("R6 hold oe", pad_oe_o, 16'h0008);

    // R10 / R11
    @(negedge clk_i); clr_i = 1'b1; @(negedge clk_i); clr_i = 1'b0; #1;
    chk("R11 clear", sticky_o, 0);
    cv = codes(3'b011, 3'b011);
    load(cv);
    strobe(16'hFFFB);           // only channel 2 low
    chk("R10 first", sticky_o, 16'h0004);
    strobe(16'hFDFF);           // channel 2 passes, channel 9 fails
    chk("R10 accumulate", sticky_o, 16'h0204);

    // R12: mismatch with no strobe
    @(negedge clk_i); pad_i = 16'h0000; #1;
    chk("R12 step_fail", step_fail_o, 0);
    @(negedge clk_i); #1;
    chk("R12 grp", fail_grp_o, 0);
    chk("R12 sticky", sticky_o, 16'h0204);

    // R11: clear wins over a same-edge fail
    @(negedge clk_i); clr_i = 1'b1; strobe_i = 1'b1; pad_i = 16'h0000;
    @(negedge clk_i); clr_i = 1'b0; strobe_i = 1'b0; #1;
    chk("R11 clr wins", sticky_o, 0);

    // R7: idle releases pins and suppresses tests
    load(codes(3'b001, 3'b011));
    run_i = 1'b0; #1;
    chk("R7 idle oe", pad_oe_o, 0);
    @(negedge clk_i); strobe_i = 1'b1; pad_i = 16'h0000; #1;
    chk("R7 idle step_fail", step_fail_o, 0);
    @(negedge clk_i); strobe_i = 1'b0; #1;
    chk("R7 idle grp", fail_grp_o, 0);
    chk("R7 idle sticky", sticky_o, 0);
    run_i = 1'b1; #1;
    chk("R7 resume oe", pad_oe_o, 16'h00FF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule